// File: doc/BRIEF.md
# Flash Unlock Command Decoder

This block watches the control strobes, address and data bus of a word-wide flash device and recognises the unlock command sequences that software writes before any array change. A write cycle is taken when the write strobe rises while the chip is selected and the output enable is inactive. A three-cycle unlock prefix followed by a fourth cycle that carries the address and data starts a word program. A six-cycle sequence starts a sector, block or whole-bank erase. When a sequence is accepted the block raises a one-cycle start pulse with the operation code, the target address and the program data. The array engine that runs the operation is outside this block.

Any cycle whose address or low data byte does not match what the sequence expects drops the decoder back to read mode. While the write strobe is high the sequence just waits, so reads to other banks can be placed between command cycles. A write-protect input fences off the upper bank: program, sector erase and block erase aimed at it are refused, and a bank erase still starts but is flagged to leave that bank untouched. A per-bank busy input refuses a new operation whose target bank is still working.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the decoder is in read mode and `op_start` is low.
- R2: Writes of 0xAA to 0x5555, 0x55 to 0x2AAA, 0xA0 to 0x5555 and then any data to any address give one `op_start` with `op_kind` 0 (program), `op_addr` equal to that address and `op_data` equal to that 16-bit data; unlock addresses are compared on bits 14:0 only.
- R3: Writes of 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA and a sixth cycle start an erase: 0x30 at any address gives `op_kind` 1 (sector), 0x50 at any address gives `op_kind` 2 (block), both with `op_addr` equal to that address; 0x10 at 0x5555 gives `op_kind` 3 (whole bank, `op_addr` 0).
- R4: Data bits 15:8 are ignored in every command cycle.
- R5: A command cycle with a wrong address or wrong low data byte returns the decoder to read mode; the rest of that sequence starts nothing, and a fresh full sequence afterwards works.
- R6: With `wp_n` low, program, sector erase and block erase whose target address has bit AW-1 set (bank 1) start nothing.
- R7: A bank erase starts regardless of `wp_n`; `keep_bank1` equals 1 exactly when `wp_n` was low on the final cycle.
- R8: A write strobe rise with `oe_n` low or `ce_n` high is not a command cycle: it neither advances nor aborts the sequence.
- R9: Any number of cycles with the write strobe high, including reads, may sit between command cycles without changing the sequence.
- R10: A program, sector or block erase whose target bank has its `bank_busy` bit set, or a bank erase while any `bank_busy` bit is set, starts nothing and returns to read mode.
- R11: `op_start` is high for exactly one clock, on the clock after the edge that detected the final write strobe rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock used to sample the flash bus |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low; cycle taken on its rise |
| addr | input | AW | Word address; bit AW-1 selects bank |
| dq | input | 16 | Data bus |
| wp_n | input | 1 | Write protect for bank 1, active low |
| bank_busy | input | 2 | Operation in progress, one bit per bank |
| op_start | output | 1 | One-cycle start request |
| op_kind | output | 2 | 0 program, 1 sector, 2 block, 3 bank erase |
| op_addr | output | AW | Target address |
| op_data | output | 16 | Program data |
| keep_bank1 | output | 1 | Bank erase must skip bank 1 |

## Verification
The checker watches every cycle for the properties that tie a start to its surroundings: that it is a single pulse following a qualified strobe rise, that a protected or busy bank is never started, that the keep flag mirrors protection on a bank erase and that program target and data match the bus. Whether a sequence was decoded at all, that aborts and malformed cycles leave nothing behind, that ignored upper bytes and interleaved reads or inhibited strobes change nothing, can only be shown by the bench sweeping every operation against every combination of protection, bank and busy state and corrupting each cycle position in turn.

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   dq,
  input  logic          wp_n,
  input  logic [1:0]    bank_busy,
  output logic          op_start,
  output logic [1:0]    op_kind,
  output logic [AW-1:0] op_addr,
  output logic [15:0]   op_data,
  output logic          keep_bank1
);
  typedef enum logic [2:0] {IDLE, UNL1, UNL2, PGM, ER3, ER4, ER5} st_t;

  localparam logic [1:0] K_PROG = 2'd0, K_SECT = 2'd1, K_BLK = 2'd2, K_BANK = 2'd3;

  st_t  st;
  logic we_q;

  wire       cyc     = ~we_q & we_n & ~ce_n & oe_n;
  wire [7:0] lo      = dq[7:0];
  wire       at_5555 = (addr[14:0] == 15'h5555);
  wire       at_2aaa = (addr[14:0] == 15'h2AAA);
  wire       bank    = addr[AW-1];
  wire       fenced  = ~wp_n & bank;
  wire       tgt_ok  = ~bank_busy[bank] & ~fenced;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= IDLE;
      we_q       <= 1'b1;
      op_start   <= 1'b0;
      op_kind    <= K_PROG;
      op_addr    <= '0;
      op_data    <= '0;
      keep_bank1 <= 1'b0;
    end else begin
      we_q     <= we_n;
      op_start <= 1'b0;
      if (cyc) begin
        st <= IDLE;
        unique case (st)
          IDLE: if (at_5555 && lo == 8'hAA) st <= UNL1;
          UNL1: if (at_2aaa && lo == 8'h55) st <= UNL2;
          UNL2: if (at_5555 && lo == 8'hA0) st <= PGM;
                else if (at_5555 && lo == 8'h80) st <= ER3;
          PGM: if (tgt_ok) begin
            op_start   <= 1'b1;
            op_kind    <= K_PROG;
            op_addr    <= addr;
            op_data    <= dq;
            keep_bank1 <= 1'b0;
          end
          ER3: if (at_5555 && lo == 8'hAA) st <= ER4;
          ER4: if (at_2aaa && lo == 8'h55) st <= ER5;
          ER5: begin
            if (lo == 8'h10 && at_5555 && bank_busy == 2'b00) begin
              op_start   <= 1'b1;
              op_kind    <= K_BANK;
              op_addr    <= '0;
              op_data    <= '0;
              keep_bank1 <= ~wp_n;
            end else if ((lo == 8'h30 || lo == 8'h50) && tgt_ok) begin
              op_start   <= 1'b1;
              op_kind    <= (lo == 8'h30) ? K_SECT : K_BLK;
              op_addr    <= addr;
              op_data    <= '0;
              keep_bank1 <= 1'b0;
            end
          end
          default: st <= IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          oe_n,
  input logic          we_n,
  input logic [AW-1:0] addr,
  input logic [15:0]   dq,
  input logic          wp_n,
  input logic [1:0]    bank_busy,
  input logic          op_start,
  input logic [1:0]    op_kind,
  input logic [AW-1:0] op_addr,
  input logic [15:0]   op_data,
  input logic          keep_bank1
);
  // R11
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> !op_start);

  // R8
  qualified_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> $past(!ce_n && oe_n && we_n));

  // R6
  protect_fence_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && op_kind != 2'd3 && !$past(wp_n)) |-> !op_addr[AW-1]);

  // R7
  keep_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && op_kind == 2'd3) |-> (keep_bank1 == !$past(wp_n)));

  // R10
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && op_kind != 2'd3) |-> !$past(bank_busy[op_addr[AW-1]]));

  // R10
  busy_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && op_kind == 2'd3) |-> ($past(bank_busy) == 2'b00));

  // R2
  prog_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && op_kind == 2'd0) |-> (op_addr == $past(addr) && op_data == $past(dq)));
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.AW(AW)) u_chk (.*);

// File: tb/flash_cmd_seq_test.sv
module flash_cmd_seq_test;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, wp_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [15:0]   dq = '0;
  logic [1:0]    bank_busy = 2'b00;
  logic          op_start, keep_bank1;
  logic [1:0]    op_kind;
  logic [AW-1:0] op_addr;
  logic [15:0]   op_data;

  int total = 0, bad = 0;
  bit done = 0;
  bit seen;
  bit inh_mode = 0;
  logic          s_start, s_keep;
  logic [1:0]    s_kind;
  logic [AW-1:0] s_addr;
  logic [15:0]   s_data;

  always #5 clk = ~clk;

  flash_cmd_seq #(.AW(AW)) uut (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic noise();
    // inhibited strobes with garbage and a read, R8 R9
    addr = 20'h0_1234; dq = 16'h5A5A;
    ce_n = 0; oe_n = 0; we_n = 0;
    @(negedge clk); we_n = 1; @(negedge clk);
    ce_n = 1; oe_n = 1; we_n = 0;
    @(negedge clk); we_n = 1; @(negedge clk);
    ce_n = 0; oe_n = 0; repeat (3) @(negedge clk);
    ce_n = 1; oe_n = 1; @(negedge clk);
    seen = seen | op_start;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    if (inh_mode) noise();
    addr = a; dq = d; ce_n = 0; oe_n = 1; we_n = 0;
    @(negedge clk);
    we_n = 1;
    @(negedge clk);
    s_start = op_start; s_kind = op_kind; s_addr = op_addr;
    s_data = op_data; s_keep = keep_bank1;
    seen = seen | op_start;
    ce_n = 1;
  endtask

  // kind 0 prog, 1 sector, 2 block, 3 bank; corrupt: -1 none, else position
  task automatic run(input int kind, input logic [AW-1:0] ta, input logic [15:0] d,
                     input logic [7:0] up, input int bad_pos, input bit bad_addr);
    logic [AW-1:0] a[6];
    logic [7:0]    v[6];
    int n;
    a[0] = 20'h05555; v[0] = 8'hAA;
    a[1] = 20'h02AAA; v[1] = 8'h55;
    if (kind == 0) begin
      a[2] = 20'h05555; v[2] = 8'hA0; n = 4;
    end else begin
      a[2] = 20'h05555; v[2] = 8'h80;
      a[3] = 20'h05555; v[3] = 8'hAA;
      a[4] = 20'h02AAA; v[4] = 8'h55;
      a[5] = (kind == 3) ? 20'h05555 : ta;
      v[5] = (kind == 1) ? 8'h30 : (kind == 2) ? 8'h50 : 8'h10;
      n = 6;
    end
    seen = 0;
    for (int i = 0; i < n; i++) begin
      if (kind == 0 && i == 3) wr(ta, d);
      else if (i == bad_pos && bad_addr) wr(a[i] ^ 20'h1, {up, v[i]});
      else if (i == bad_pos) wr(a[i], {up, v[i] ^ 8'h01});
      else wr(a[i], {up, v[i]});
    end
    @(negedge clk);
    chk(op_start == 0, "R11", op_start, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(op_start == 0, "R1", op_start, 0);
    rst_n = 1;
    @(negedge clk);
    chk(op_start == 0, "R1", op_start, 0);

    // full sweep: kind x wp x bank x busy x upper byte x inhibit noise
    for (int k = 0; k < 4; k++)
      for (int w = 0; w < 2; w++)
        for (int b = 0; b < 2; b++)
          for (int bz = 0; bz < 4; bz++)
            for (int u = 0; u < 2; u++) begin
              logic [AW-1:0] ta;
              logic [15:0] d;
              bit exp_s;
              ta = {b[0], 19'h01234 + 19'(k * 37 + bz)};
              d = 16'hC3A0 ^ 16'(k * 911 + w * 5 + bz);
              wp_n = w[0]; bank_busy = bz[1:0];
              inh_mode = u[0];
              if (k == 3) exp_s = (bz == 0);
              else exp_s = !bank_busy[b] && !(w == 0 && b == 1);
              run(k, ta, d, u[0] ? 8'hE7 : 8'h00, -1, 0);
              if (k == 3) chk(s_start == exp_s, "R7 R10", s_start, exp_s);
              else if (w == 0 && b == 1) chk(s_start == exp_s, "R6", s_start, exp_s);
              else chk(s_start == exp_s, "R10", s_start, exp_s);
              if (u == 1) chk(s_start == exp_s, "R4 R8 R9", s_start, exp_s);
              if (exp_s) begin
                chk(s_kind == k[1:0], k == 0 ? "R2" : "R3", s_kind, k);
                if (k == 0) begin
                  chk(s_addr == ta, "R2", s_addr, ta);
                  chk(s_data == d, "R2", s_data, d);
                end else if (k == 3) begin
                  chk(s_addr == 0, "R3", s_addr, 0);
                  chk(s_keep == (w == 0), "R7", s_keep, w == 0);
                end else chk(s_addr == ta, "R3", s_addr, ta);
              end
            end
    inh_mode = 0; wp_n = 1; bank_busy = 0;

    // abort at each position, data then address
    for (int k = 0; k < 4; k++)
      for (int p = 0; p < 6; p++)
        for (int ba = 0; ba < 2; ba++) begin
          if (k == 0 && p > 2) continue;
          if (ba == 1 && k != 3 && p == 5) continue;
          run(k, 20'h0_0777, 16'h1234, 8'h00, p, ba[0]);
          chk(seen == 0, "R5", seen, 0);
          run(k, 20'h0_0777, 16'h1234, 8'h00, -1, 0);
          chk(s_start == 1 && s_kind == k[1:0], "R5", {s_start, s_kind}, {1'b1, k[1:0]});
        end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule